// File: doc/BRIEF.md
# Command Effects Log Engine

This block builds a log of every command that a device's mailbox supports and serves it on request. After reset it walks a read-only command table through an address port. It visits one table entry per clock, going through every command set and, within each set, every command in ascending order. For each entry marked present it stores a four-byte record. The record holds the 16-bit opcode (set in the upper byte, command in the lower byte) and the entry's 16-bit side-effect mask. The block counts the records as it stores them.

Once the scan is complete the block takes two kinds of request. A list request returns a single log descriptor: a fixed 128-bit identifier and the log size in bytes. A read request carries an identifier, a byte offset and a byte length. The block rejects it when the window overruns the payload buffer or when the identifier is wrong. Otherwise it streams the requested bytes, one per clock, tagged with their position in the payload, and then gives a completion. While the scan runs, or while a request is being served, `busy` is high and requests are ignored.

Top module: `cmd_effect_log`

## Requirements
- R1: After reset the table is visited in set-major, command-minor order, one entry per clock. `busy` stays high for exactly 2^(SET_BITS+CMD_BITS) clocks. Only entries with `tbl_present` high produce a record, and records keep visiting order.
- R2: Each record occupies four log bytes, little-endian. Byte 0 is the command number, byte 1 the set number, byte 2 the effect mask bits 7:0 and byte 3 the effect mask bits 15:8. The effect mask (bit 1 configuration change, bit 2 data change, bit 3 policy change, bit 4 log change) is stored unchanged.
- R3: At most MAX_REC records are kept. Present entries found after the log is full are dropped, and the count stays at MAX_REC.
- R4: A list request (`req_kind`=0) completes with code 0x00, `rsp_entries`=1, `rsp_log_id`=LOG_ID and `rsp_log_size` equal to 4 times the record count.
- R5: A read request (`req_kind`=1) whose offset plus length exceeds PAYLOAD_BYTES completes with code 0x02, `rsp_len`=0 and no data bytes. A sum equal to PAYLOAD_BYTES is accepted.
- R6: A read request within bounds whose `req_id` differs from LOG_ID completes with code 0x03, `rsp_len`=0 and no data bytes.
- R7: The bounds check takes precedence. A request that fails both checks gets code 0x02.
- R8: A valid read with length L streams L bytes with `out_idx` running 0 to L-1. Byte i is the log byte at address offset+i, and addresses past the end of the log read as zero. The completion then carries code 0x00 and `rsp_len`=L.
- R9: A valid read with length 0 completes with code 0x00 and `rsp_len`=0 and streams no bytes.
- R10: Requests presented while `busy` is high are ignored: no bytes and no completion follow from them.
- R11: `rsp_valid` is a one-clock pulse. A rejected, list or zero-length request completes in the clock after acceptance. A read of length L shows byte i in the i-th clock after acceptance and completes L clocks after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, restarts the scan |
| tbl_set | output | SET_BITS | Command set of the table entry being examined |
| tbl_cmd | output | CMD_BITS | Command number of the table entry being examined |
| tbl_present | input | 1 | Addressed entry has a handler (combinational from the address) |
| tbl_effect | input | 16 | Side-effect mask of the addressed entry |
| busy | output | 1 | Scan running or request in service; requests ignored |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_kind | input | 1 | 0 = list logs, 1 = read log |
| req_id | input | 128 | Log identifier for a read |
| req_off | input | LEN_W | Byte offset for a read |
| req_len | input | LEN_W | Byte length for a read |
| rsp_valid | output | 1 | Completion pulse |
| rsp_code | output | 8 | Completion code (0x00, 0x02, 0x03) |
| rsp_len | output | LEN_W | Bytes returned by a read |
| rsp_entries | output | 8 | Number of log descriptors (list only) |
| rsp_log_id | output | 128 | Identifier of the log (list only) |
| rsp_log_size | output | LEN_W | Log size in bytes (list only) |
| out_valid | output | 1 | Streamed data byte valid |
| out_idx | output | LEN_W | Payload position of the streamed byte |
| out_byte | output | 8 | Streamed data byte |

## Verification
The bench builds the engine with 3 set bits and 3 command bits, so a full scan takes 64 clocks and the scan-length check runs quickly. It sets MAX_REC to 8 and feeds nine present entries, so the last table entry is dropped and saturation becomes visible. PAYLOAD_BYTES is 48, above the 32-byte log, so reads can cross the log end into zero fill. Offsets can land exactly on the buffer limit or one byte past it. An 8-bit length field keeps the stream windows short.

// File: rtl/cel_pkg.sv
package cel_pkg;

  localparam logic [7:0] CODE_OK        = 8'h00;
  localparam logic [7:0] CODE_BAD_INPUT = 8'h02;
  localparam logic [7:0] CODE_UNSUPP    = 8'h03;

  localparam logic KIND_LIST = 1'b0;
  localparam logic KIND_READ = 1'b1;

  typedef enum logic [1:0] {
    SV_IDLE   = 2'd0,
    SV_STREAM = 2'd1,
    SV_REPLY  = 2'd2
  } srv_state_e;

  // bits [15:0] land in log bytes 0..1, bits [31:16] in bytes 2..3
  typedef struct packed {
    logic [15:0] effect;
    logic [15:0] opcode;
  } cel_rec_t;

  function automatic logic [15:0] make_opcode(input logic [7:0] set_num,
                                              input logic [7:0] cmd_num);
    return {set_num, cmd_num};
  endfunction

  function automatic logic [7:0] rec_lane(input cel_rec_t rec, input logic [1:0] lane);
    logic [7:0] b;
    case (lane)
      2'd0:    b = rec.opcode[7:0];
      2'd1:    b = rec.opcode[15:8];
      2'd2:    b = rec.effect[7:0];
      default: b = rec.effect[15:8];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/cel_scanner.sv
module cel_scanner
  import cel_pkg::*;
#(
  parameter int SET_BITS = 8,
  parameter int CMD_BITS = 8,
  parameter int MAX_REC  = 64,
  parameter int CNT_W    = $clog2(MAX_REC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [SET_BITS-1:0] tbl_set,
  output logic [CMD_BITS-1:0] tbl_cmd,
  input  logic                tbl_present,
  input  logic [15:0]         tbl_effect,
  output logic                wr_en,
  output logic [CNT_W-1:0]    wr_idx,
  output cel_rec_t            wr_rec,
  output logic [CNT_W-1:0]    rec_count,
  output logic                scan_done
);

  localparam int IDX_W = SET_BITS + CMD_BITS;
  localparam logic [IDX_W-1:0] IDX_LAST = '1;

  logic [IDX_W-1:0] idx_q;
  logic             scanning_q;
  logic [CNT_W-1:0] count_q;
  logic [7:0]       set_ext, cmd_ext;
  logic             room;
  logic             drop_evt;

  assign tbl_set = idx_q[IDX_W-1:CMD_BITS];
  assign tbl_cmd = idx_q[CMD_BITS-1:0];

  generate
    if (SET_BITS < 8) begin : g_set_pad
      assign set_ext = {{(8-SET_BITS){1'b0}}, tbl_set};
    end else begin : g_set_full
      assign set_ext = tbl_set;
    end
    if (CMD_BITS < 8) begin : g_cmd_pad
      assign cmd_ext = {{(8-CMD_BITS){1'b0}}, tbl_cmd};
    end else begin : g_cmd_full
      assign cmd_ext = tbl_cmd;
    end
  endgenerate

  assign room     = 32'(count_q) < 32'(MAX_REC);
  assign wr_en    = scanning_q && tbl_present && room;
  assign drop_evt = scanning_q && tbl_present && !room;
  assign wr_idx   = count_q;

  always_comb begin
    wr_rec        = '0;
    wr_rec.opcode = make_opcode(set_ext, cmd_ext);
    wr_rec.effect = tbl_effect;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      scanning_q <= 1'b1;
      count_q    <= '0;
    end else begin
      if (scanning_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == IDX_LAST) scanning_q <= 1'b0;
      end
      if (wr_en) count_q <= count_q + 1'b1;
    end
  end

  assign rec_count = count_q;
  assign scan_done = !scanning_q;

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rec_count) <= 32'(MAX_REC)); // R3
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (32'(rec_count) == 32'(MAX_REC))); // R3
  AST_LOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> $stable(rec_count)); // R1
  AST_SCAN_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> scan_done); // R1

endmodule

// File: rtl/cel_store.sv
module cel_store
  import cel_pkg::*;
#(
  parameter int MAX_REC = 64,
  parameter int CNT_W   = $clog2(MAX_REC + 1),
  parameter int ADDR_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_idx,
  input  cel_rec_t          wr_rec,
  input  logic [CNT_W-1:0]  rec_count,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte
);

  localparam int RI_W = (MAX_REC > 1) ? $clog2(MAX_REC) : 1;

  cel_rec_t mem_q [MAX_REC];

  logic [ADDR_W-3:0] word;
  logic [1:0]        lane;
  logic              in_log;
  cel_rec_t          rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_REC; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_idx[RI_W-1:0]] <= wr_rec;
    end
  end

  assign word   = rd_addr[ADDR_W-1:2];
  assign lane   = rd_addr[1:0];
  assign in_log = 32'(word) < 32'(rec_count);

  always_comb begin
    rec     = '0;
    rd_byte = '0;
    if (in_log) begin
      rec     = mem_q[word[RI_W-1:0]];
      rd_byte = rec_lane(rec, lane);
    end
  end

  AST_WRITE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_idx) < 32'(MAX_REC))); // R3

endmodule

// File: rtl/cel_server.sv
module cel_server
  import cel_pkg::*;
#(
  parameter int           LEN_W         = 16,
  parameter int           PAYLOAD_BYTES = 512,
  parameter int           CNT_W         = 7,
  parameter logic [127:0] LOG_ID        = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_done,
  input  logic [CNT_W-1:0]  rec_count,
  output logic              busy,
  input  logic              req_valid,
  input  logic              req_kind,
  input  logic [127:0]      req_id,
  input  logic [LEN_W-1:0]  req_off,
  input  logic [LEN_W-1:0]  req_len,
  output logic [LEN_W:0]    rd_addr,
  input  logic [7:0]        rd_byte,
  output logic              rsp_valid,
  output logic [7:0]        rsp_code,
  output logic [LEN_W-1:0]  rsp_len,
  output logic [7:0]        rsp_entries,
  output logic [127:0]      rsp_log_id,
  output logic [LEN_W-1:0]  rsp_log_size,
  output logic              out_valid,
  output logic [LEN_W-1:0]  out_idx,
  output logic [7:0]        out_byte
);

  function automatic logic past_limit(input logic [LEN_W-1:0] off,
                                      input logic [LEN_W-1:0] len);
    logic [31:0] sum;
    sum = 32'(off) + 32'(len);
    return sum > 32'(PAYLOAD_BYTES);
  endfunction

  function automatic logic [LEN_W-1:0] log_bytes(input logic [CNT_W-1:0] cnt);
    logic [31:0] t;
    t = 32'(cnt) * 32'd4;
    return t[LEN_W-1:0];
  endfunction

  srv_state_e       state_q;
  logic [LEN_W-1:0] off_q, len_q, cnt_q, rlen_q;
  logic [7:0]       code_q;
  logic             list_q;

  logic accept, acc_read, acc_list;
  logic bounds_bad, id_bad;
  logic stream_last;

  assign busy       = !scan_done || (state_q != SV_IDLE);
  assign accept     = req_valid && !busy;
  assign acc_read   = accept && (req_kind == KIND_READ);
  assign acc_list   = accept && (req_kind == KIND_LIST);
  assign bounds_bad = past_limit(req_off, req_len);
  assign id_bad     = req_id != LOG_ID;
  assign stream_last = (state_q == SV_STREAM) && (cnt_q == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SV_IDLE;
      off_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      rlen_q  <= '0;
      code_q  <= CODE_OK;
      list_q  <= 1'b0;
    end else begin
      case (state_q)
        SV_IDLE: begin
          if (acc_list) begin
            state_q <= SV_REPLY;
            code_q  <= CODE_OK;
            rlen_q  <= '0;
            list_q  <= 1'b1;
          end else if (acc_read) begin
            list_q <= 1'b0;
            rlen_q <= '0;
            if (bounds_bad) begin
              state_q <= SV_REPLY;
              code_q  <= CODE_BAD_INPUT;
            end else if (id_bad) begin
              state_q <= SV_REPLY;
              code_q  <= CODE_UNSUPP;
            end else if (req_len == '0) begin
              state_q <= SV_REPLY;
              code_q  <= CODE_OK;
            end else begin
              state_q <= SV_STREAM;
              off_q   <= req_off;
              len_q   <= req_len;
              cnt_q   <= '0;
            end
          end
        end
        SV_STREAM: begin
          cnt_q <= cnt_q + 1'b1;
          if (stream_last) begin
            state_q <= SV_REPLY;
            code_q  <= CODE_OK;
            rlen_q  <= len_q;
          end
        end
        default: begin
          state_q <= SV_IDLE;
          list_q  <= 1'b0;
        end
      endcase
    end
  end

  assign rd_addr      = {1'b0, off_q} + {1'b0, cnt_q};
  assign out_valid    = (state_q == SV_STREAM);
  assign out_idx      = cnt_q;
  assign out_byte     = out_valid ? rd_byte : 8'h00;

  assign rsp_valid    = (state_q == SV_REPLY);
  assign rsp_code     = rsp_valid ? code_q : 8'h00;
  assign rsp_len      = rsp_valid ? rlen_q : '0;
  assign rsp_entries  = (rsp_valid && list_q) ? 8'd1 : 8'd0;
  assign rsp_log_id   = (rsp_valid && list_q) ? LOG_ID : '0;
  assign rsp_log_size = (rsp_valid && list_q) ? log_bytes(rec_count) : '0;

  AST_BOUNDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_read && bounds_bad) |=> (rsp_valid && rsp_code == CODE_BAD_INPUT)); // R7
  AST_ID_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_read && !bounds_bad && id_bad) |=> (rsp_valid && rsp_code == CODE_UNSUPP)); // R6
  AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != CODE_OK) |-> (rsp_len == '0)); // R5
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11
  AST_STREAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_idx) < 32'(len_q))); // R8
  AST_QUIET_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |-> !(rsp_valid || out_valid)); // R10
  AST_STREAM_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(rd_addr) < 32'(PAYLOAD_BYTES))); // R5

endmodule

// File: rtl/cmd_effect_log.sv
module cmd_effect_log
  import cel_pkg::*;
#(
  parameter int           SET_BITS      = 8,
  parameter int           CMD_BITS      = 8,
  parameter int           MAX_REC       = 64,
  parameter int           PAYLOAD_BYTES = 512,
  parameter int           LEN_W         = 16,
  parameter logic [127:0] LOG_ID        = 128'h5A3C_19E2_7D40_4B8F_A61C_0E92_D3B7_4F15
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [SET_BITS-1:0] tbl_set,
  output logic [CMD_BITS-1:0] tbl_cmd,
  input  logic                tbl_present,
  input  logic [15:0]         tbl_effect,
  output logic                busy,
  input  logic                req_valid,
  input  logic                req_kind,
  input  logic [127:0]        req_id,
  input  logic [LEN_W-1:0]    req_off,
  input  logic [LEN_W-1:0]    req_len,
  output logic                rsp_valid,
  output logic [7:0]          rsp_code,
  output logic [LEN_W-1:0]    rsp_len,
  output logic [7:0]          rsp_entries,
  output logic [127:0]        rsp_log_id,
  output logic [LEN_W-1:0]    rsp_log_size,
  output logic                out_valid,
  output logic [LEN_W-1:0]    out_idx,
  output logic [7:0]          out_byte
);

  localparam int CNT_W  = $clog2(MAX_REC + 1);
  localparam int ADDR_W = LEN_W + 1;

  logic             wr_en;
  logic [CNT_W-1:0] wr_idx;
  cel_rec_t         wr_rec;
  logic [CNT_W-1:0] rec_count;
  logic             scan_done;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]       rd_byte;

  cel_scanner #(
    .SET_BITS(SET_BITS), .CMD_BITS(CMD_BITS), .MAX_REC(MAX_REC), .CNT_W(CNT_W)
  ) u_scan (
    .clk(clk), .rst_n(rst_n),
    .tbl_set(tbl_set), .tbl_cmd(tbl_cmd),
    .tbl_present(tbl_present), .tbl_effect(tbl_effect),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_rec(wr_rec),
    .rec_count(rec_count), .scan_done(scan_done)
  );

  cel_store #(
    .MAX_REC(MAX_REC), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_rec(wr_rec),
    .rec_count(rec_count), .rd_addr(rd_addr), .rd_byte(rd_byte)
  );

  cel_server #(
    .LEN_W(LEN_W), .PAYLOAD_BYTES(PAYLOAD_BYTES), .CNT_W(CNT_W), .LOG_ID(LOG_ID)
  ) u_srv (
    .clk(clk), .rst_n(rst_n),
    .scan_done(scan_done), .rec_count(rec_count), .busy(busy),
    .req_valid(req_valid), .req_kind(req_kind), .req_id(req_id),
    .req_off(req_off), .req_len(req_len),
    .rd_addr(rd_addr), .rd_byte(rd_byte),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_len(rsp_len),
    .rsp_entries(rsp_entries), .rsp_log_id(rsp_log_id), .rsp_log_size(rsp_log_size),
    .out_valid(out_valid), .out_idx(out_idx), .out_byte(out_byte)
  );

endmodule

// File: tb/tb_cmd_effect_log.sv
`timescale 1ns/1ps
module tb_cmd_effect_log;

  localparam int SB = 3, CB = 3, MR = 8, PB = 48, LW = 8;
  localparam logic [127:0] BENCH_ID = 128'hC0DE_7711_2B4A_9E05_F00D_3C6A_81D2_44E9;
  localparam logic [127:0] WRONG_ID = BENCH_ID ^ 128'h0000_0400_0000_0000_0000_0000_0000_0000;

  // populated table entries (set, cmd, effect), not listed in scan order
  localparam int NT = 9;
  localparam int T_SET [NT] = '{4, 0, 7, 1, 2, 0, 5, 7, 1};
  localparam int T_CMD [NT] = '{5, 3, 6, 0, 2, 1, 0, 7, 7};
  localparam int T_EFF [NT] = '{16'h001E, 16'h0002, 16'h0012, 16'h0010, 16'h0008,
                                16'h0000, 16'h0004, 16'h0002, 16'h0006};

  // request vectors: kind, offset, length, id good, expected code
  localparam int NV = 10;
  localparam int V_KIND [NV] = '{0, 1, 1, 1, 1, 1, 1, 1, 1, 1};
  localparam int V_OFF  [NV] = '{0, 0, 5, 28, 40, 41, 0, 45, 10, 0};
  localparam int V_LEN  [NV] = '{0, 8, 3, 8, 8, 8, 4, 9, 0, 32};
  localparam int V_IDOK [NV] = '{1, 1, 1, 1, 1, 1, 0, 0, 1, 1};
  localparam int V_CODE [NV] = '{0, 0, 0, 0, 0, 2, 3, 2, 0, 0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SB-1:0] tbl_set;
  logic [CB-1:0] tbl_cmd;
  logic tbl_present;
  logic [15:0] tbl_effect;
  logic busy, req_valid, req_kind;
  logic [127:0] req_id;
  logic [LW-1:0] req_off, req_len;
  logic rsp_valid;
  logic [7:0] rsp_code, rsp_entries, out_byte;
  logic [LW-1:0] rsp_len, rsp_log_size, out_idx;
  logic [127:0] rsp_log_id;
  logic out_valid;

  always #2.5 clk = ~clk;

  cmd_effect_log #(.SET_BITS(SB), .CMD_BITS(CB), .MAX_REC(MR), .PAYLOAD_BYTES(PB),
                   .LEN_W(LW), .LOG_ID(BENCH_ID)) dut (
    .clk(clk), .rst_n(rst_n), .tbl_set(tbl_set), .tbl_cmd(tbl_cmd),
    .tbl_present(tbl_present), .tbl_effect(tbl_effect), .busy(busy),
    .req_valid(req_valid), .req_kind(req_kind), .req_id(req_id),
    .req_off(req_off), .req_len(req_len), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_len(rsp_len), .rsp_entries(rsp_entries),
    .rsp_log_id(rsp_log_id), .rsp_log_size(rsp_log_size),
    .out_valid(out_valid), .out_idx(out_idx), .out_byte(out_byte));

  always_comb begin
    tbl_present = 1'b0;
    tbl_effect  = 16'h0000;
    for (int k = 0; k < NT; k++) begin
      if (int'(tbl_set) == T_SET[k] && int'(tbl_cmd) == T_CMD[k]) begin
        tbl_present = 1'b1;
        tbl_effect  = T_EFF[k][15:0];
      end
    end
  end

  int checks = 0, fails = 0;
  int exp_n = 0;
  int exp_op [MR];
  int exp_eff [MR];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int exp_byte(input int a);
    int w, l;
    w = a / 4; l = a % 4;
    if (w >= exp_n) return 0;
    case (l)
      0: return exp_op[w] & 8'hFF;
      1: return (exp_op[w] >> 8) & 8'hFF;
      2: return exp_eff[w] & 8'hFF;
      default: return (exp_eff[w] >> 8) & 8'hFF;
    endcase
  endfunction

  // result of one request
  int got_code, got_len, got_nbytes, got_lat, got_bad_idx, got_first_bad;
  int got_entries, got_size;
  logic [127:0] got_id;
  int got [64];

  task automatic run_req(input int kind, input int off, input int len, input logic [127:0] id);
    int cyc;
    bit done;
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_kind = kind[0]; req_id = id;
    req_off = off[LW-1:0]; req_len = len[LW-1:0];
    @(negedge clk);
    req_valid = 1'b0;
    got_nbytes = 0; got_bad_idx = 0; got_lat = -1; done = 0; cyc = 0;
    while (!done && cyc < 200) begin
      if (out_valid) begin
        if (int'(out_idx) != got_nbytes) got_bad_idx++;
        if (got_nbytes < 64) got[got_nbytes] = int'(out_byte);
        got_nbytes++;
      end
      if (rsp_valid) begin
        done = 1; got_lat = cyc;
        got_code = int'(rsp_code); got_len = int'(rsp_len);
        got_entries = int'(rsp_entries); got_size = int'(rsp_log_size);
        got_id = rsp_log_id;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
  endtask

  initial begin
    #750000;
    fails++; checks++;
    $display("FAIL R8 watchdog actual=hang expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int scan_cycles, stray, exp_l, exp_lat, mism;
    req_valid = 1'b0; req_kind = 1'b0; req_id = '0; req_off = '0; req_len = '0;

    // independent model of the log: set-major walk, capacity MR
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 8; c++)
        for (int k = 0; k < NT; k++)
          if (T_SET[k] == s && T_CMD[k] == c && exp_n < MR) begin
            exp_op[exp_n] = (s << 8) | c;
            exp_eff[exp_n] = T_EFF[k];
            exp_n++;
          end

    repeat (3) @(negedge clk);
    // reset state
    check(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
    check(!rsp_valid && !out_valid, "R10 quiet in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;

    // a request during the scan must be ignored (R10)
    scan_cycles = 0; stray = 0;
    req_valid = 1'b1; req_kind = 1'b1; req_id = BENCH_ID; req_off = '0; req_len = 8'd4;
    while (busy && scan_cycles < 1000) begin
      @(negedge clk);
      scan_cycles++;
      if (scan_cycles == 5) req_valid = 1'b0;
      if (rsp_valid || out_valid) stray++;
    end
    check(scan_cycles == 64, "R1 scan length", scan_cycles, 64);
    check(stray == 0, "R10 ignored during scan", stray, 0);
    repeat (4) begin
      @(negedge clk);
      if (rsp_valid || out_valid) stray++;
    end
    check(stray == 0, "R10 no late response", stray, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      run_req(V_KIND[v], V_OFF[v], V_LEN[v], V_IDOK[v] != 0 ? BENCH_ID : WRONG_ID);
      check(got_code == V_CODE[v], $sformatf("R5 R6 R7 vec%0d code", v), got_code, V_CODE[v]);
      exp_l = (V_KIND[v] == 1 && V_CODE[v] == 0) ? V_LEN[v] : 0;
      check(got_len == exp_l, $sformatf("R8 R9 vec%0d rsp_len", v), got_len, exp_l);
      check(got_nbytes == exp_l, $sformatf("R8 vec%0d byte count", v), got_nbytes, exp_l);
      exp_lat = exp_l;
      check(got_lat == exp_lat, $sformatf("R11 vec%0d latency", v), got_lat, exp_lat);
      check(got_bad_idx == 0, $sformatf("R8 vec%0d out_idx order", v), got_bad_idx, 0);
      mism = 0; got_first_bad = -1;
      for (int i = 0; i < got_nbytes && i < 64; i++)
        if (got[i] != exp_byte(V_OFF[v] + i)) begin
          mism++;
          if (got_first_bad < 0) got_first_bad = i;
        end
      if (mism != 0)
        check(0, $sformatf("R1 R2 R3 vec%0d byte %0d", v, got_first_bad),
              got[got_first_bad], exp_byte(V_OFF[v] + got_first_bad));
      else
        check(1, "R2 bytes", 0, 0);
      if (V_KIND[v] == 0) begin
        check(got_entries == 1, "R4 entries", got_entries, 1);
        check(got_size == 4 * exp_n, "R4 R3 log size", got_size, 4 * exp_n);
        check(got_id == BENCH_ID, "R4 log id", int'(got_id[31:0]), int'(BENCH_ID[31:0]));
      end else begin
        check(got_entries == 0, "R4 entries on read", got_entries, 0);
      end
    end

    // saturation: record 7 is (7,6); (7,7) was dropped
    check(exp_byte(28) == 6 && exp_byte(29) == 7, "R3 model", exp_byte(28), 6);
    run_req(1, 28, 4, BENCH_ID);
    check(got[0] == 6 && got[1] == 7 && got[2] == 8'h12, "R3 last kept record",
          got[0] | (got[1] << 8) | (got[2] << 16), 32'h120706);

    // request while streaming is ignored (R10)
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_kind = 1'b1; req_id = BENCH_ID; req_off = 8'd4; req_len = 8'd6;
    @(negedge clk);
    req_kind = 1'b0; stray = 0;
    while (!rsp_valid) @(negedge clk);
    check(int'(rsp_len) == 6, "R8 read under competing request", int'(rsp_len), 6);
    req_valid = 1'b0;
    repeat (5) begin
      @(negedge clk);
      if (rsp_valid || out_valid) stray++;
    end
    check(stray == 0, "R10 ignored while serving", stray, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule